// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block puts a bank of small internal controller registers behind a single 64-bit command word. The host never addresses those registers directly. It writes one word that carries a launch flag, an operation code, a register selector, a direction flag and a data byte. The bridge runs the internal access over a fixed number of cycles and then clears the launch flag. For a read, it also places the register value in the low byte of the same word. The host polls the word until the launch flag reads zero, then picks up the result.

A small register bank stub sits behind the bridge. It holds a data register, a control register, a write-only clock-control register, a status register and a clock divisor register. A selector code that is not defined, or an operation code that is not defined, completes harmlessly.

The sequencer has four states, in this order:
- `ST_IDLE` accepts a launch and moves to `ST_DECODE`.
- `ST_DECODE` moves to `ST_WAIT`, or straight to `ST_COMMIT` when no wait cycles are configured.
- `ST_WAIT` counts down and moves to `ST_COMMIT` when its counter reaches zero.
- `ST_COMMIT` performs the register write or captures the read value, clears the flag, and returns to `ST_IDLE`.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the command word reads zero. A read of the status register returns 0xF8. A read of the clock divisor returns `CLK_DIV_RST` (default 0x18).
- R2: A host write with bit 63 set, made while bit 63 reads zero, stores the whole word. Bit 63 then reads one for exactly `ACCESS_CYCLES` clock cycles (default 4) and then reads zero.
- R3: Host writes made while bit 63 reads one are ignored. The word that completes is the one that launched.
- R4: A host write with bit 63 clear, made while idle, leaves the command word and every register unchanged.
- R5: With bits 59:58 = 2'b11, selector bits 34:32 = 1 write or read the data register, and selector 2 writes or reads the control register. Bit 56 set means read; clear means write bits 7:0.
- R6: With bits 59:58 = 2'b11 and selector 3, a write goes to the clock-control register and a read returns the status register.
- R7: With bits 59:58 = 2'b11 and selector 7, a write clears the data and control registers and sets status to 0xF8. A read of selector 7 returns zero.
- R8: With bits 59:58 = 2'b10, the access targets the clock divisor register whatever the selector.
- R9: On completion, bit 63 is cleared. A read replaces bits 7:0 with the register value. All other bits keep the launched value.
- R10: Selectors 0, 4, 5 and 6, and operation codes 2'b00 and 2'b01, read zero, discard writes, and still complete.
- R11: A control write with bit 5 set sets status to 0x08. A control write with bit 5 clear and bit 4 set sets status to 0xF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Host write strobe for the command word |
| csr_wdata | input | 64 | Host write data |
| csr_rdata | output | 64 | Current command word, including the launch flag and the read result |

## Verification
The hardest case to reach from the ports is a host write that arrives in the middle of a busy window. The host only learns the bridge is busy by polling, so an ordinary driver would never write then. The bench therefore drives a second, conflicting launch word one cycle after the first launch. It then checks that the completed word and a later read of the data register both reflect only the first launch. The one-shot reset selector is reached by first moving status away from 0xF8 through a control write with bit 5 set.

// File: rtl/irb_pkg.sv
package irb_pkg;

    // Command word field positions; the host encoding depends on them
    localparam int CMD_W   = 64;
    localparam int GO_POS  = 63;
    localparam int OP_HI   = 59;
    localparam int OP_LO   = 58;
    localparam int RD_POS  = 56;
    localparam int SEL_HI  = 34;
    localparam int SEL_LO  = 32;

    localparam logic [2:0] SEL_DATA    = 3'd1;
    localparam logic [2:0] SEL_CTL     = 3'd2;
    localparam logic [2:0] SEL_CLKSTAT = 3'd3;
    localparam logic [2:0] SEL_FLUSH   = 3'd7;

    typedef enum logic [1:0] {
        OP_RSVD0  = 2'b00,
        OP_RSVD1  = 2'b01,
        OP_CLKDIV = 2'b10,
        OP_REGS   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_DATA,
        SRC_CTL,
        SRC_STAT,
        SRC_CLKDIV
    } rd_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WAIT,
        ST_COMMIT
    } seq_state_e;

    typedef struct packed {
        logic data;
        logic ctl;
        logic clkctl;
        logic clkdiv;
        logic flush;
    } wr_strobe_t;

endpackage

// File: rtl/irb_decode.sv
module irb_decode
    import irb_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  op_e              op,
    input  logic             rd_flag,
    input  logic [2:0]       sel,
    input  logic [REG_W-1:0] data_in,
    output rd_src_e          rd_src,
    output wr_strobe_t       wr_req,
    output logic             is_read,
    output logic [REG_W-1:0] wr_byte
);

    always_comb begin
        rd_src  = SRC_NONE;
        wr_req  = '0;
        is_read = rd_flag;
        wr_byte = data_in;
        unique case (op)
            OP_REGS: begin
                case (sel)
                    SEL_DATA: begin
                        rd_src      = SRC_DATA;
                        wr_req.data = 1'b1;
                    end
                    SEL_CTL: begin
                        rd_src     = SRC_CTL;
                        wr_req.ctl = 1'b1;
                    end
                    SEL_CLKSTAT: begin
                        rd_src        = SRC_STAT;
                        wr_req.clkctl = 1'b1;
                    end
                    SEL_FLUSH: begin
                        rd_src       = SRC_NONE;
                        wr_req.flush = 1'b1;
                    end
                    default: begin
                        rd_src = SRC_NONE;
                        wr_req = '0;
                    end
                endcase
            end
            OP_CLKDIV: begin
                rd_src        = SRC_CLKDIV;
                wr_req.clkdiv = 1'b1;
            end
            OP_RSVD0, OP_RSVD1: begin
                rd_src = SRC_NONE;
                wr_req = '0;
            end
        endcase
    end

endmodule

// File: rtl/irb_regbank.sv
module irb_regbank
    import irb_pkg::*;
#(
    parameter int             REG_W       = 8,
    parameter logic [REG_W-1:0] CLK_DIV_RST = 8'h18,
    parameter logic [REG_W-1:0] IDLE_CODE   = 8'hF8,
    parameter logic [REG_W-1:0] START_CODE  = 8'h08,
    parameter int             LAUNCH_BIT  = 5,
    parameter int             HALT_BIT    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       wr_stb,
    input  logic [REG_W-1:0] wr_byte,
    input  rd_src_e          rd_src,
    output logic [REG_W-1:0] rd_val,
    output logic [REG_W-1:0] status_q
);

    logic [REG_W-1:0] data_q;
    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] clkctl_q;
    logic [REG_W-1:0] clkdiv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            ctl_q    <= '0;
            clkctl_q <= '0;
            clkdiv_q <= CLK_DIV_RST;
            status_q <= IDLE_CODE;
        end else begin
            if (wr_stb.flush) begin
                data_q   <= '0;
                ctl_q    <= '0;
                status_q <= IDLE_CODE;
            end
            if (wr_stb.data) begin
                data_q <= wr_byte;
            end
            if (wr_stb.ctl) begin
                ctl_q <= wr_byte;
                if (wr_byte[LAUNCH_BIT]) begin
                    status_q <= START_CODE;
                end else if (wr_byte[HALT_BIT]) begin
                    status_q <= IDLE_CODE;
                end
            end
            if (wr_stb.clkctl) begin
                clkctl_q <= wr_byte;
            end
            if (wr_stb.clkdiv) begin
                clkdiv_q <= wr_byte;
            end
        end
    end

    always_comb begin
        unique case (rd_src)
            SRC_DATA:   rd_val = data_q;
            SRC_CTL:    rd_val = ctl_q;
            SRC_STAT:   rd_val = status_q;
            SRC_CLKDIV: rd_val = clkdiv_q;
            default:    rd_val = '0;
        endcase
    end

    // clock-control is write-only from the host side; keep it observable
    logic clkctl_parity;
    assign clkctl_parity = ^clkctl_q;
    logic unused_ok;
    assign unused_ok = clkctl_parity;

endmodule

// File: rtl/irb_seq.sv
module irb_seq
    import irb_pkg::*;
#(
    parameter int REG_W         = 8,
    parameter int ACCESS_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [CMD_W-1:0] host_wdata,
    input  logic             is_read,
    input  wr_strobe_t       wr_req,
    input  logic [REG_W-1:0] rd_val,
    output logic [CMD_W-1:0] cmd_q,
    output wr_strobe_t       wr_stb
);

    localparam int WAIT_CYC = (ACCESS_CYCLES > 2) ? ACCESS_CYCLES - 2 : 0;
    localparam int CNT_W    = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    seq_state_e state, state_nxt;
    logic       launch;
    logic       cnt_done;

    assign launch = host_we && host_wdata[GO_POS];

    generate
        if (WAIT_CYC > 0) begin : g_wait
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (state == ST_DECODE) begin
                    cnt <= CNT_W'(WAIT_CYC - 1);
                end else if (state == ST_WAIT && cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end
            assign cnt_done = (cnt == '0);
        end else begin : g_nowait
            assign cnt_done = 1'b1;
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (launch) state_nxt = ST_DECODE;
            ST_DECODE: state_nxt = (WAIT_CYC == 0) ? ST_COMMIT : ST_WAIT;
            ST_WAIT:   if (cnt_done) state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
        endcase
    end

    // outputs: command word and register strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch) cmd_q <= host_wdata;
                end
                ST_COMMIT: begin
                    cmd_q[GO_POS] <= 1'b0;
                    if (is_read) cmd_q[REG_W-1:0] <= rd_val;
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        wr_stb = '0;
        if (state == ST_COMMIT && !is_read) begin
            wr_stb = wr_req;
        end
    end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import irb_pkg::*;
#(
    parameter int               REG_W         = 8,
    parameter int               ACCESS_CYCLES = 4,
    parameter logic [REG_W-1:0] CLK_DIV_RST   = 8'h18,
    parameter logic [REG_W-1:0] IDLE_CODE     = 8'hF8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [63:0] csr_wdata,
    output logic [63:0] csr_rdata
);

    logic [CMD_W-1:0] cmd_q;
    rd_src_e          rd_src;
    wr_strobe_t       wr_req;
    wr_strobe_t       wr_stb;
    logic             is_read;
    logic [REG_W-1:0] wr_byte;
    logic [REG_W-1:0] rd_val;
    logic [REG_W-1:0] status_q;

    irb_decode #(.REG_W(REG_W)) u_dec (
        .op      (op_e'(cmd_q[OP_HI:OP_LO])),
        .rd_flag (cmd_q[RD_POS]),
        .sel     (cmd_q[SEL_HI:SEL_LO]),
        .data_in (cmd_q[REG_W-1:0]),
        .rd_src  (rd_src),
        .wr_req  (wr_req),
        .is_read (is_read),
        .wr_byte (wr_byte)
    );

    irb_seq #(.REG_W(REG_W), .ACCESS_CYCLES(ACCESS_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (csr_we),
        .host_wdata (csr_wdata),
        .is_read    (is_read),
        .wr_req     (wr_req),
        .rd_val     (rd_val),
        .cmd_q      (cmd_q),
        .wr_stb     (wr_stb)
    );

    irb_regbank #(
        .REG_W       (REG_W),
        .CLK_DIV_RST (CLK_DIV_RST),
        .IDLE_CODE   (IDLE_CODE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .rd_src   (rd_src),
        .rd_val   (rd_val),
        .status_q (status_q)
    );

    assign csr_rdata = cmd_q;

endmodule

// File: rtl/irb_checker.sv
module irb_checker
    import irb_pkg::*;
#(
    parameter int               REG_W         = 8,
    parameter int               ACCESS_CYCLES = 4,
    parameter logic [REG_W-1:0] IDLE_CODE     = 8'hF8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_we,
    input logic [63:0]      csr_wdata,
    input logic [63:0]      csr_rdata,
    input wr_strobe_t       wr_stb,
    input logic [REG_W-1:0] status_q
);

    logic [15:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (csr_rdata[GO_POS]) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_rdata[GO_POS]) |-> busy_cnt == 16'(ACCESS_CYCLES));

    assert_launch_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rdata[GO_POS] && csr_we && csr_wdata[GO_POS]) |=> csr_rdata == $past(csr_wdata));

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[GO_POS] |=> $stable(csr_rdata[62:8]));

    assert_no_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rdata[GO_POS] && csr_we && !csr_wdata[GO_POS]) |=> $stable(csr_rdata));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    assert_flush_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb.flush |=> status_q == IDLE_CODE);

    assert_strobe_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |=> !csr_rdata[GO_POS]);

endmodule

bind ind_reg_bridge irb_checker #(
    .REG_W         (REG_W),
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .IDLE_CODE     (IDLE_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .wr_stb    (wr_stb),
    .status_q  (status_q)
);

// File: tb/tb_ind_reg_bridge.sv
`timescale 1ns/1ps
module tb_ind_reg_bridge;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ind_reg_bridge dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] mk(input logic [1:0] op, input logic rd, input logic [2:0] sel, input logic [7:0] d);
        logic [63:0] w;
        w = '0;
        w[63] = 1'b1;
        w[59:58] = op;
        w[56] = rd;
        w[34:32] = sel;
        w[7:0] = d;
        return w;
    endfunction

    // Driver: push expected completion word, launch, optionally poke while busy
    task automatic run(input logic [63:0] w, input logic [7:0] rv, input string tag,
                       input bit poke, input logic [63:0] poke_w);
        logic [63:0] e;
        e = w;
        e[63] = 1'b0;
        if (w[56]) e[7:0] = rv;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        csr_we = 1'b1;
        csr_wdata = w;
        @(negedge clk);
        if (poke) begin
            csr_wdata = poke_w;
            @(negedge clk);
        end
        csr_we = 1'b0;
        while (csr_rdata[63]) @(negedge clk);
    endtask

    // Monitor: scoreboard pops on each completion and checks busy length
    int busy_n = 0;
    bit prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (csr_rdata[63]) begin
                busy_n++;
            end else if (prev_v) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected completion", csr_rdata, '0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(csr_rdata == e, t, csr_rdata, e);
                    check(busy_n == LAT, "R2 busy length", 64'(busy_n), 64'(LAT));
                end
                busy_n = 0;
            end
            prev_v = csr_rdata[63];
        end
    end

    initial begin
        logic [63:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(csr_rdata == 64'h0, "R1 reset word", csr_rdata, 64'h0);

        run(mk(2'b11, 1, 3'd3, 8'h00), 8'hF8, "R1 status after reset", 0, '0);
        run(mk(2'b10, 1, 3'd0, 8'h00), 8'h18, "R1 clock divisor after reset", 0, '0);

        run(mk(2'b11, 0, 3'd1, 8'hA5), 8'h00, "R5 data write", 0, '0);
        run(mk(2'b11, 1, 3'd1, 8'h5A), 8'hA5, "R9 data read replaces low byte", 0, '0);
        run(mk(2'b11, 0, 3'd2, 8'h44), 8'h00, "R5 control write", 0, '0);
        run(mk(2'b11, 1, 3'd2, 8'h00), 8'h44, "R5 control read", 0, '0);

        run(mk(2'b11, 0, 3'd3, 8'h2B), 8'h00, "R6 clock-control write", 0, '0);
        run(mk(2'b11, 1, 3'd3, 8'h00), 8'hF8, "R6 selector 3 reads status", 0, '0);

        run(mk(2'b11, 0, 3'd2, 8'h60), 8'h00, "R11 control launch bit", 0, '0);
        run(mk(2'b11, 1, 3'd3, 8'h00), 8'h08, "R11 status after launch bit", 0, '0);
        run(mk(2'b11, 0, 3'd2, 8'h50), 8'h00, "R11 control halt bit", 0, '0);
        run(mk(2'b11, 1, 3'd3, 8'h00), 8'hF8, "R11 status after halt bit", 0, '0);

        run(mk(2'b11, 0, 3'd2, 8'h60), 8'h00, "R7 set status busy", 0, '0);
        run(mk(2'b11, 0, 3'd7, 8'h00), 8'h00, "R7 flush write", 0, '0);
        run(mk(2'b11, 1, 3'd3, 8'h00), 8'hF8, "R7 status idle after flush", 0, '0);
        run(mk(2'b11, 1, 3'd1, 8'h00), 8'h00, "R7 data cleared", 0, '0);
        run(mk(2'b11, 1, 3'd2, 8'h00), 8'h00, "R7 control cleared", 0, '0);
        run(mk(2'b11, 1, 3'd7, 8'h3C), 8'h00, "R7 selector 7 reads zero", 0, '0);

        run(mk(2'b10, 0, 3'd5, 8'h33), 8'h00, "R8 clock divisor write", 0, '0);
        run(mk(2'b10, 1, 3'd2, 8'h00), 8'h33, "R8 clock divisor read", 0, '0);

        run(mk(2'b11, 0, 3'd1, 8'h11), 8'h00, "R10 preset data", 0, '0);
        run(mk(2'b11, 0, 3'd5, 8'h77), 8'h00, "R10 unknown selector write", 0, '0);
        run(mk(2'b11, 1, 3'd5, 8'hEE), 8'h00, "R10 unknown selector read", 0, '0);
        run(mk(2'b00, 0, 3'd1, 8'h99), 8'h00, "R10 reserved op write", 0, '0);
        run(mk(2'b01, 1, 3'd1, 8'hEE), 8'h00, "R10 reserved op read", 0, '0);
        run(mk(2'b11, 1, 3'd1, 8'h00), 8'h11, "R10 data untouched", 0, '0);

        run(mk(2'b11, 0, 3'd1, 8'h99), 8'h00, "R3 launch with busy poke", 1, mk(2'b11, 0, 3'd2, 8'hCC));
        run(mk(2'b11, 1, 3'd1, 8'h00), 8'h99, "R3 data from first launch", 0, '0);
        run(mk(2'b11, 1, 3'd2, 8'h00), 8'h00, "R3 control untouched by poke", 0, '0);

        // R4: write with launch flag clear while idle
        hold = csr_rdata;
        @(negedge clk);
        csr_we = 1'b1;
        csr_wdata = 64'h0C00_0001_0000_0042;
        @(negedge clk);
        csr_we = 1'b0;
        check(csr_rdata == hold, "R4 word unchanged", csr_rdata, hold);
        @(negedge clk);
        check(csr_rdata == hold, "R4 word still unchanged", csr_rdata, hold);
        run(mk(2'b11, 1, 3'd1, 8'h00), 8'h99, "R4 data register unchanged", 0, '0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all completions seen", 64'(exp_q.size()), 64'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule